// File: doc/BRIEF.md
# Data Abort Fault Status Recorder

This block gathers every abort condition that one memory access can raise and turns them into a single 4-bit fault status code. The MMU walk logic, the bus interface and the core's mode state supply the inputs. The block also runs the alignment check itself, using the access size and the low address bits. It also checks for the 26-bit-mode vector hit, which is a data access into the low exception vector window. A fixed priority picks one cause. Each walk-related cause has a pair of codes, one for a first-level (section) walk and one for a page walk, and the `pageWalk` input selects between them.

Each aborted access raises a one-cycle flag to the core, `dataAbort` or `prefetchAbort`. Only data aborts write the status, the domain and the faulting address into the record registers. A recorded data abort sets a pending flag. While that flag is set the record is frozen, so a later access cannot overwrite it. This applies to an instruction-side abort as well as to a second data abort. The core clears the flag with `abortAck` once it has entered its abort handler.

Top module: `data_abort_recorder`

## Requirements
- R1: With `alignChkEn`=1, a data access raises status 0001 with domain 0 when it is a word access (`accSize`=10 or 11) and address bits [1:0] are not 00, or when it is a halfword access (`accSize`=01) and address bit 0 is 1.
- R2: A byte access (`accSize`=00), any instruction fetch, and any access made while `alignChkEn`=0 never produce status 0001.
- R3: A data access made with `mode26`=1 to an address from 0x00 to 0x1F raises status 0000 with domain 0. An instruction fetch to the same addresses raises nothing from this check.
- R4: When several causes are present, exactly one status is recorded. The order from highest to lowest is: alignment, vector, walk external abort, translation fault, domain fault, permission fault, bus external abort.
- R5: A walk external abort records 1100 with domain 0 when `pageWalk`=0. It records 1110 with `descDomain` when `pageWalk`=1.
- R6: A translation fault records 0101 with domain 0 when `pageWalk`=0. It records 0111 with `descDomain` when `pageWalk`=1.
- R7: A domain fault records 1001 or 1011, and a permission fault records 1101 or 1111, for `pageWalk`=0 or 1 respectively. Both carry `descDomain`.
- R8: A bus external abort records 0100 or 0110 when `lineFetch`=1 and 1000 or 1010 when `lineFetch`=0, for `pageWalk`=0 or 1 respectively, with `descDomain`.
- R9: A faulting data access pulses `dataAbort` for one cycle, one clock after the access. On the same edge it loads `faultStatus`, `faultDomain` and `faultAddr` (the access address) and sets `abortPending`.
- R10: A faulting instruction fetch pulses `prefetchAbort` one clock after the access. It leaves the record and `abortPending` unchanged.
- R11: While `abortPending`=1, no access changes the record. `abortAck` clears `abortPending` on the next edge, after which a new data abort is recorded again.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access is presented this cycle |
| accIsData | input | 1 | 1 = data access, 0 = instruction fetch |
| accSize | input | 2 | 00 byte, 01 halfword, 1x word |
| accAddr | input | 32 | Virtual address of the access |
| alignChkEn | input | 1 | Alignment checking enabled |
| mode26 | input | 1 | Core is in a 26-bit mode |
| pageWalk | input | 1 | Fault arose on a page-table walk (0 = section) |
| walkExtAbort | input | 1 | External abort during a descriptor fetch |
| walkInvalid | input | 1 | Fetched descriptor is marked invalid |
| domainDenied | input | 1 | Domain check refused the access |
| permDenied | input | 1 | Access permission check refused the access |
| busExtAbort | input | 1 | External abort on the data transfer |
| lineFetch | input | 1 | Data transfer was a cache line fill |
| descDomain | input | 4 | Domain number from the first-level descriptor |
| abortAck | input | 1 | Core has entered the data abort handler |
| dataAbort | output | 1 | One-cycle data abort flag |
| prefetchAbort | output | 1 | One-cycle instruction abort flag |
| abortPending | output | 1 | A data abort record awaits acknowledge |
| faultStatus | output | 4 | Recorded fault status code |
| faultDomain | output | 4 | Recorded domain number |
| faultAddr | output | 32 | Recorded faulting virtual address |

## Verification
The bench targets priority collisions. One case is a misaligned halfword inside the vector window, which must give 0001 and not 0000. Another is a walk external abort together with an invalid descriptor, which must give 1100 and not 0101. A domain fault together with a permission fault must report the domain fault. A design with a swapped priority chain records the lower-ranked code.

The bench also exercises:
- byte and instruction accesses at misaligned addresses;
- an instruction fetch inside the vector window;
- the section/page and line-fill code pairs, where a wrong bit selection shows up as the twin code;
- domain zeroing for causes raised before a descriptor exists.

For the pending record, the bench sends a second data abort and then an instruction abort before acknowledging. A recorder that ignores the pending flag would replace the first address and status.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [3:0] {
    FS_VECTOR      = 4'b0000,
    FS_ALIGN       = 4'b0001,
    FS_BUS_LINE_S  = 4'b0100,
    FS_TRANS_S     = 4'b0101,
    FS_BUS_LINE_P  = 4'b0110,
    FS_TRANS_P     = 4'b0111,
    FS_BUS_PLAIN_S = 4'b1000,
    FS_DOMAIN_S    = 4'b1001,
    FS_BUS_PLAIN_P = 4'b1010,
    FS_DOMAIN_P    = 4'b1011,
    FS_WALK_EXT_S  = 4'b1100,
    FS_PERM_S      = 4'b1101,
    FS_WALK_EXT_P  = 4'b1110,
    FS_PERM_P      = 4'b1111
  } fault_code_t;

  typedef struct packed {
    logic loadRecord;
    logic flagData;
    logic flagInstr;
  } rec_strobe_t;

endpackage

// File: rtl/abort_encoder.sv
module abort_encoder
  import fsr_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int DOM_W   = 4,
  parameter int VEC_TOP = 5
) (
  input  logic              accIsData,
  input  logic [1:0]        accSize,
  input  logic [VA_W-1:0]   accAddr,
  input  logic              alignChkEn,
  input  logic              mode26,
  input  logic              pageWalk,
  input  logic              walkExtAbort,
  input  logic              walkInvalid,
  input  logic              domainDenied,
  input  logic              permDenied,
  input  logic              busExtAbort,
  input  logic              lineFetch,
  input  logic [DOM_W-1:0]  descDomain,
  output logic              anyFault,
  output fault_code_t       faultCode,
  output logic [DOM_W-1:0]  faultDom
);

  localparam int HI_W = VA_W - VEC_TOP;

  logic wordAcc, halfAcc, misAligned, vecHit, domOk;

  assign wordAcc    = accSize[1];
  assign halfAcc    = (accSize == 2'b01);
  assign misAligned = alignChkEn && accIsData &&
                      ((wordAcc && (accAddr[1:0] != 2'b00)) || (halfAcc && accAddr[0]));
  assign vecHit     = accIsData && mode26 && (accAddr[VA_W-1:VEC_TOP] == HI_W'(0));

  always_comb begin
    anyFault  = 1'b1;
    domOk     = 1'b1;
    faultCode = FS_VECTOR;
    if (misAligned) begin
      faultCode = FS_ALIGN;
      domOk     = 1'b0;
    end else if (vecHit) begin
      faultCode = FS_VECTOR;
      domOk     = 1'b0;
    end else if (walkExtAbort) begin
      faultCode = pageWalk ? FS_WALK_EXT_P : FS_WALK_EXT_S;
      domOk     = pageWalk;
    end else if (walkInvalid) begin
      faultCode = pageWalk ? FS_TRANS_P : FS_TRANS_S;
      domOk     = pageWalk;
    end else if (domainDenied) begin
      faultCode = pageWalk ? FS_DOMAIN_P : FS_DOMAIN_S;
    end else if (permDenied) begin
      faultCode = pageWalk ? FS_PERM_P : FS_PERM_S;
    end else if (busExtAbort) begin
      if (lineFetch) faultCode = pageWalk ? FS_BUS_LINE_P : FS_BUS_LINE_S;
      else           faultCode = pageWalk ? FS_BUS_PLAIN_P : FS_BUS_PLAIN_S;
    end else begin
      anyFault = 1'b0;
      domOk    = 1'b0;
    end
    faultDom = domOk ? descDomain : '0;
  end

endmodule

// File: rtl/fsr_control.sv
module fsr_control
  import fsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accIsData,
  input  logic        anyFault,
  input  logic        abortAck,
  output rec_strobe_t strobe,
  output logic        dataAbort,
  output logic        prefetchAbort,
  output logic        abortPending
);

  logic pendingQ;

  always_comb begin
    strobe.flagData   = accValid && anyFault && accIsData;
    strobe.flagInstr  = accValid && anyFault && !accIsData;
    strobe.loadRecord = strobe.flagData && !pendingQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ      <= 1'b0;
      dataAbort     <= 1'b0;
      prefetchAbort <= 1'b0;
    end else begin
      dataAbort     <= strobe.flagData;
      prefetchAbort <= strobe.flagInstr;
      if (strobe.loadRecord)  pendingQ <= 1'b1;
      else if (abortAck)      pendingQ <= 1'b0;
    end
  end

  assign abortPending = pendingQ;

  a_r9_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRecord |=> abortPending);

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (abortPending && abortAck) |=> !abortPending);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dataAbort && prefetchAbort));

endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int DOM_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rec_strobe_t       strobe,
  input  fault_code_t       faultCode,
  input  logic [DOM_W-1:0]  faultDom,
  input  logic [VA_W-1:0]   accAddr,
  input  logic [1:0]        accSize,
  output logic [3:0]        faultStatus,
  output logic [DOM_W-1:0]  faultDomain,
  output logic [VA_W-1:0]   faultAddr
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultDomain <= '0;
      faultAddr   <= '0;
    end else if (strobe.loadRecord) begin
      faultStatus <= faultCode;
      faultDomain <= faultDom;
      faultAddr   <= accAddr;
    end
  end

  a_r9_addr_captured: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRecord |=> (faultAddr == $past(accAddr)));

  a_r2_byte_never_aligns: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRecord && accSize == 2'b00) |=> (faultStatus != 4'b0001));

endmodule

// File: rtl/data_abort_recorder.sv
module data_abort_recorder
  import fsr_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int DOM_W   = 4,
  parameter int VEC_TOP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accIsData,
  input  logic [1:0]        accSize,
  input  logic [VA_W-1:0]   accAddr,
  input  logic              alignChkEn,
  input  logic              mode26,
  input  logic              pageWalk,
  input  logic              walkExtAbort,
  input  logic              walkInvalid,
  input  logic              domainDenied,
  input  logic              permDenied,
  input  logic              busExtAbort,
  input  logic              lineFetch,
  input  logic [DOM_W-1:0]  descDomain,
  input  logic              abortAck,
  output logic              dataAbort,
  output logic              prefetchAbort,
  output logic              abortPending,
  output logic [3:0]        faultStatus,
  output logic [DOM_W-1:0]  faultDomain,
  output logic [VA_W-1:0]   faultAddr
);

  logic             anyFault;
  fault_code_t      faultCode;
  logic [DOM_W-1:0] faultDom;
  rec_strobe_t      strobe;

  abort_encoder #(.VA_W(VA_W), .DOM_W(DOM_W), .VEC_TOP(VEC_TOP)) uEnc (
    .accIsData(accIsData), .accSize(accSize), .accAddr(accAddr),
    .alignChkEn(alignChkEn), .mode26(mode26), .pageWalk(pageWalk),
    .walkExtAbort(walkExtAbort), .walkInvalid(walkInvalid),
    .domainDenied(domainDenied), .permDenied(permDenied),
    .busExtAbort(busExtAbort), .lineFetch(lineFetch), .descDomain(descDomain),
    .anyFault(anyFault), .faultCode(faultCode), .faultDom(faultDom)
  );

  fsr_control uCtl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsData(accIsData),
    .anyFault(anyFault), .abortAck(abortAck), .strobe(strobe),
    .dataAbort(dataAbort), .prefetchAbort(prefetchAbort), .abortPending(abortPending)
  );

  fsr_datapath #(.VA_W(VA_W), .DOM_W(DOM_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .faultCode(faultCode),
    .faultDom(faultDom), .accAddr(accAddr), .accSize(accSize),
    .faultStatus(faultStatus), .faultDomain(faultDomain), .faultAddr(faultAddr)
  );

  a_r11_record_frozen: assert property (@(posedge clk) disable iff (!rstN)
    abortPending |=> ($stable(faultAddr) && $stable(faultStatus) && $stable(faultDomain)));

  a_r10_fetch_keeps_record: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accIsData) |=> ($stable(faultAddr) && $stable(faultStatus)));

  a_r10_fetch_no_pending: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accIsData && !abortPending) |=> !abortPending);

endmodule

// File: tb/sim_data_abort_recorder.sv
module sim_data_abort_recorder;

  typedef struct packed {
    logic        isData;
    logic [1:0]  size;
    logic [31:0] addr;
    logic        alignEn;
    logic        m26;
    logic        pw;
    logic        wExt;
    logic        wInv;
    logic        dDen;
    logic        pDen;
    logic        bExt;
    logic        lf;
    logic [3:0]  dom;
    logic [3:0]  expStat;
    logic [3:0]  expDom;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b10, 32'h0000_1002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h5, 4'b0001, 4'h0}, // R1 word
    '{1'b1, 2'b01, 32'h0000_1001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 4'b0001, 4'h0}, // R1 half
    '{1'b1, 2'b01, 32'h0000_1002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5, 4'b0101, 4'h0}, // R6 section
    '{1'b1, 2'b00, 32'h0000_1003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 4'b1000, 4'h3}, // R2 byte
    '{1'b1, 2'b10, 32'h0000_2003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h7, 4'b0111, 4'h7}, // R2 off, R6 page
    '{1'b1, 2'b10, 32'h0000_001C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 4'b0000, 4'h0}, // R3
    '{1'b1, 2'b10, 32'h0000_0020, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 4'b1101, 4'h2}, // R3 edge, R7
    '{1'b1, 2'b10, 32'h0000_3000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h8, 4'b1100, 4'h0}, // R5 R4
    '{1'b1, 2'b10, 32'h0000_3004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h9, 4'b1110, 4'h9}, // R5 page
    '{1'b1, 2'b10, 32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h4, 4'b1011, 4'h4}, // R7 R4
    '{1'b1, 2'b10, 32'h0000_4004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 4'b1001, 4'hF}, // R7
    '{1'b1, 2'b10, 32'h0000_4008, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 4'b1111, 4'h6}, // R7 R4
    '{1'b1, 2'b10, 32'h0000_5000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h1, 4'b0100, 4'h1}, // R8
    '{1'b1, 2'b10, 32'h0000_5004, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h1, 4'b0110, 4'h1}, // R8
    '{1'b1, 2'b10, 32'h0000_5008, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hA, 4'b1010, 4'hA}, // R8
    '{1'b1, 2'b01, 32'h0000_001D, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h2, 4'b0001, 4'h0}, // R4 align>vector
    '{1'b1, 2'b10, 32'h0000_0004, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hC, 4'b0000, 4'h0}  // R4 vector>walk
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 0, accIsData = 0, alignChkEn = 0, mode26 = 0, pageWalk = 0;
  logic walkExtAbort = 0, walkInvalid = 0, domainDenied = 0, permDenied = 0;
  logic busExtAbort = 0, lineFetch = 0, abortAck = 0;
  logic [1:0]  accSize = 2'b00;
  logic [31:0] accAddr = '0;
  logic [3:0]  descDomain = '0;
  logic dataAbort, prefetchAbort, abortPending;
  logic [3:0]  faultStatus, faultDomain;
  logic [31:0] faultAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  data_abort_recorder u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsData(accIsData),
    .accSize(accSize), .accAddr(accAddr), .alignChkEn(alignChkEn), .mode26(mode26),
    .pageWalk(pageWalk), .walkExtAbort(walkExtAbort), .walkInvalid(walkInvalid),
    .domainDenied(domainDenied), .permDenied(permDenied), .busExtAbort(busExtAbort),
    .lineFetch(lineFetch), .descDomain(descDomain), .abortAck(abortAck),
    .dataAbort(dataAbort), .prefetchAbort(prefetchAbort), .abortPending(abortPending),
    .faultStatus(faultStatus), .faultDomain(faultDomain), .faultAddr(faultAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    accIsData = v.isData; accSize = v.size; accAddr = v.addr;
    alignChkEn = v.alignEn; mode26 = v.m26; pageWalk = v.pw;
    walkExtAbort = v.wExt; walkInvalid = v.wInv; domainDenied = v.dDen;
    permDenied = v.pDen; busExtAbort = v.bExt; lineFetch = v.lf; descDomain = v.dom;
  endtask

  // one access: drive at negedge, captured at posedge, sampled next negedge
  task automatic access(input vec_t v);
    @(negedge clk);
    drive(v);
    accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic ack();
    abortAck = 1'b1;
    @(negedge clk);
    abortAck = 1'b0;
  endtask

  function automatic vec_t mk(input logic isD, input logic [1:0] sz, input logic [31:0] a,
                              input logic al, input logic m, input logic pD);
    vec_t v = '0;
    v.isData = isD; v.size = sz; v.addr = a; v.alignEn = al; v.m26 = m; v.pDen = pD;
    v.dom = 4'h3;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 dataAbort", {31'b0, dataAbort}, 32'd0);
    check("R12 pending", {31'b0, abortPending}, 32'd0);
    check("R12 status", {28'b0, faultStatus}, 32'd0);
    check("R12 addr", faultAddr, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i]);
      check("R9 dataAbort pulse", {31'b0, dataAbort}, 32'd1);
      check("R4 status", {28'b0, faultStatus}, {28'b0, VECS[i].expStat});
      check("R4 domain", {28'b0, faultDomain}, {28'b0, VECS[i].expDom});
      check("R9 addr", faultAddr, VECS[i].addr);
      check("R9 pending", {31'b0, abortPending}, 32'd1);
      ack();
      check("R11 ack clears", {31'b0, abortPending}, 32'd0);
      check("R9 one-cycle pulse", {31'b0, dataAbort}, 32'd0);
    end

    // R2: byte, no other fault -> no abort at all
    access(mk(1'b1, 2'b00, 32'h0000_7003, 1'b1, 1'b0, 1'b0));
    check("R2 byte no abort", {31'b0, dataAbort}, 32'd0);
    // R2: misaligned instruction fetch -> no abort
    access(mk(1'b0, 2'b10, 32'h0000_7002, 1'b1, 1'b0, 1'b0));
    check("R2 fetch no align", {31'b0, prefetchAbort}, 32'd0);
    // R3: instruction fetch into vector window -> no abort
    access(mk(1'b0, 2'b10, 32'h0000_0008, 1'b1, 1'b1, 1'b0));
    check("R3 fetch not vector", {31'b0, prefetchAbort}, 32'd0);
    check("R3 record untouched", faultAddr, 32'h0000_0004);

    // R10: instruction abort flagged, record untouched
    access(mk(1'b0, 2'b10, 32'h0000_8000, 1'b1, 1'b0, 1'b1));
    check("R10 prefetch pulse", {31'b0, prefetchAbort}, 32'd1);
    check("R10 no data flag", {31'b0, dataAbort}, 32'd0);
    check("R10 addr kept", faultAddr, 32'h0000_0004);
    check("R10 no pending", {31'b0, abortPending}, 32'd0);

    // R11: pending freezes record
    access(mk(1'b1, 2'b10, 32'h0000_9000, 1'b1, 1'b0, 1'b1));
    check("R11 first recorded", faultAddr, 32'h0000_9000);
    check("R11 first status", {28'b0, faultStatus}, 32'hD);
    access(mk(1'b1, 2'b10, 32'h0000_A002, 1'b1, 1'b0, 1'b0));
    check("R11 second still flagged", {31'b0, dataAbort}, 32'd1);
    check("R11 addr frozen", faultAddr, 32'h0000_9000);
    check("R11 status frozen", {28'b0, faultStatus}, 32'hD);
    access(mk(1'b0, 2'b10, 32'h0000_B000, 1'b1, 1'b0, 1'b1));
    check("R11 fetch cannot overwrite", faultAddr, 32'h0000_9000);
    check("R11 still pending", {31'b0, abortPending}, 32'd1);
    ack();
    check("R11 cleared", {31'b0, abortPending}, 32'd0);
    access(mk(1'b1, 2'b01, 32'h0000_C001, 1'b1, 1'b0, 1'b0));
    check("R11 new record", faultAddr, 32'h0000_C001);
    check("R1 new status", {28'b0, faultStatus}, 32'h1);

    // R12: reset clears record
    rstN = 1'b0;
    @(negedge clk);
    check("R12 reset pending", {31'b0, abortPending}, 32'd0);
    check("R12 reset addr", faultAddr, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule